// File: doc/BRIEF.md
# Socket Status-Change Interrupt Unit

This block watches the live signals of one removable-card socket: two card-detect lines, two battery-voltage-detect lines, write-protect, ready and a power-good flag. It passes them through a two-flop synchronizer and shows them in a read-only status register. It also latches three kinds of change event: card insertion or removal, the battery entering its warning state, and the battery entering its dead state.

Software reaches the block through an 8-bit register index. For this socket the index is `{CTRL_ID, SOCK_ID, offset[5:0]}`. The status register is at offset 1, the change register at offset 4 and the interrupt configuration register at offset 5. A read of the change register returns the latched events and clears them in the same access. The interrupt request is the OR of every latched event whose enable bit is set. The configuration register also holds a 4-bit steering number, which is driven out next to the request. Software reads the change register once after reset to discard any events left from start-up.

Top module: `csc_irq_unit`

## Requirements
- R1: A read of offset 1 returns `{0, pwr, rdy, wp, det[1:0], bvd[1:0]}`, with bit 7 reading 0. The value reflects the pin levels after two clock edges of synchronization.
- R2: The block responds only when index bit 7 equals CTRL_ID and bit 6 equals SOCK_ID. Any other access reads 0, leaves every register unchanged and clears nothing.
- R3: The card counts as present only when det == 2'b11. Change bit 3 is set on every rise and every fall of the synchronized present condition. A change on one detect line while the other line is 0 sets nothing.
- R4: Battery warning is bvd == 2'b10, and entering it sets change bit 1. Battery dead is bvd[1] == 0, and entering it sets change bit 0. Returning to bvd == 2'b11 sets no bit.
- R5: Change bits stay set until the change register (offset 4) is read. The read returns them in bits 3, 1 and 0, and all other bits read 0.
- R6: A read of offset 4 clears the change bits at that clock edge. irq_o is low in the cycle after the read when no new event arrived.
- R7: If an event arrives in the same cycle as the clearing read, its bit is set after that read.
- R8: Offset 5 is read/write. Bits 7:4 hold the steering number and bits 3, 1 and 0 enable the matching change bits. Bit 2 always reads 0. irq_num_o equals bits 7:4.
- R9: irq_o is the OR over bits 3, 1 and 0 of (change AND enable). A disabled source never raises irq_o, but its event is still latched and can be read.
- R10: After reset all registers are 0 and irq_o and irq_num_o are 0.
- R11: Writes to offsets 1 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_i | input | 2 | Raw card-detect lines, 1 = contact made |
| bvd_i | input | 2 | Raw battery-voltage-detect lines |
| wp_i | input | 1 | Raw write-protect line |
| rdy_i | input | 1 | Raw ready line |
| pwr_good_i | input | 1 | Socket power-good flag |
| reg_sel_i | input | 8 | Register index |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid while reg_rd_i is high |
| irq_o | output | 1 | Status-change interrupt request |
| irq_num_o | output | 4 | Interrupt steering number |

## Verification
The bench times a card removal so that the event lands on the exact edge of a clearing read. A design that lets the clear win would drop the event, and irq_o would stay low afterwards. It raises one detect line alone, then removes the card one line at a time. A design that used OR instead of AND would then report a change bit where none is expected. With an enable cleared, the bench inserts a card and checks both that irq_o stays low and that the change bit is still set. It also reads through a foreign socket index while an event is pending. Incomplete index decoding would show up there as a cleared event or a non-zero read.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int IDX_W = 8;
  localparam int OFF_W = 6;
  localparam int DAT_W = 8;
  localparam int STEER_W = 4;

  localparam logic [OFF_W-1:0] OFF_STAT = 6'd1;
  localparam logic [OFF_W-1:0] OFF_CHG  = 6'd4;
  localparam logic [OFF_W-1:0] OFF_CFG  = 6'd5;

  localparam int BIT_CD    = 3;
  localparam int BIT_BWARN = 1;
  localparam int BIT_BDEAD = 0;

  localparam logic [DAT_W-1:0] SRC_MASK = 8'h0B;
  localparam logic [DAT_W-1:0] CFG_MASK = 8'hFB;

  typedef struct packed {
    logic       pwr;
    logic       rdy;
    logic       wp;
    logic [1:0] det;
    logic [1:0] bvd;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/csc_event.sv
module csc_event
  import csc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pins_t            pins_i,
  input  logic             ack_i,
  output logic [DAT_W-1:0] ev_o,
  output logic [DAT_W-1:0] chg_o
);
  logic present, warn, dead;
  logic prev_present_q, prev_warn_q, prev_dead_q;
  logic [DAT_W-1:0] chg_q;

  assign present = &pins_i.det;
  assign warn    = (pins_i.bvd == 2'b10);
  assign dead    = ~pins_i.bvd[1];

  always_comb begin
    ev_o = '0;
    ev_o[BIT_CD]    = present ^ prev_present_q;
    ev_o[BIT_BWARN] = warn & ~prev_warn_q;
    ev_o[BIT_BDEAD] = dead & ~prev_dead_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_present_q <= 1'b0;
      prev_warn_q    <= 1'b0;
      prev_dead_q    <= 1'b0;
      chg_q          <= '0;
    end else begin
      prev_present_q <= present;
      prev_warn_q    <= warn;
      prev_dead_q    <= dead;
      // a new event outranks the clearing read
      chg_q          <= (ack_i ? '0 : chg_q) | ev_o;
    end
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
#(
  parameter bit CTRL_ID = 1'b0,
  parameter bit SOCK_ID = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   sel_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DAT_W-1:0]   wdata_i,
  input  pins_t              pins_i,
  input  logic [DAT_W-1:0]   chg_i,
  output logic [DAT_W-1:0]   rdata_o,
  output logic [DAT_W-1:0]   cfg_o,
  output logic               ack_o
);
  logic             hit;
  logic [OFF_W-1:0] off;
  logic [DAT_W-1:0] cfg_q;

  assign hit = (sel_i[IDX_W-1] == CTRL_ID) && (sel_i[IDX_W-2] == SOCK_ID);
  assign off = sel_i[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cfg_q <= '0;
    else if (wr_i && hit && off == OFF_CFG) cfg_q <= wdata_i & CFG_MASK;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && hit) begin
      unique case (off)
        OFF_STAT: rdata_o = {1'b0, pins_i};
        OFF_CHG:  rdata_o = chg_i & SRC_MASK;
        OFF_CFG:  rdata_o = cfg_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign ack_o = rd_i && hit && (off == OFF_CHG);
  assign cfg_o = cfg_q;
endmodule

// File: rtl/csc_irq_unit.sv
module csc_irq_unit
  import csc_pkg::*;
#(
  parameter bit CTRL_ID = 1'b0,
  parameter bit SOCK_ID = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         det_i,
  input  logic [1:0]         bvd_i,
  input  logic               wp_i,
  input  logic               rdy_i,
  input  logic               pwr_good_i,
  input  logic [IDX_W-1:0]   reg_sel_i,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [DAT_W-1:0]   reg_wdata_i,
  output logic [DAT_W-1:0]   reg_rdata_o,
  output logic               irq_o,
  output logic [STEER_W-1:0] irq_num_o
);
  pins_t            raw_w, pins_w;
  logic [DAT_W-1:0] ev_w, chg_w, cfg_w;
  logic             ack_w;

  assign raw_w = '{pwr: pwr_good_i, rdy: rdy_i, wp: wp_i, det: det_i, bvd: bvd_i};

  csc_sync #(.W(PINS_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_w),
    .q_o   (pins_w)
  );

  csc_event u_event (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_w),
    .ack_i (ack_w),
    .ev_o  (ev_w),
    .chg_o (chg_w)
  );

  csc_regs #(.CTRL_ID(CTRL_ID), .SOCK_ID(SOCK_ID)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (reg_sel_i),
    .rd_i   (reg_rd_i),
    .wr_i   (reg_wr_i),
    .wdata_i(reg_wdata_i),
    .pins_i (pins_w),
    .chg_i  (chg_w),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg_w),
    .ack_o  (ack_w)
  );

  assign irq_o     = |(chg_w & cfg_w & SRC_MASK);
  assign irq_num_o = cfg_w[DAT_W-1 -: STEER_W];
endmodule

module csc_irq_unit_chk
  import csc_pkg::*;
#(
  parameter bit CTRL_ID = 1'b0,
  parameter bit SOCK_ID = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [IDX_W-1:0]   reg_sel_i,
  input logic               reg_rd_i,
  input logic               reg_wr_i,
  input logic [DAT_W-1:0]   reg_wdata_i,
  input logic [DAT_W-1:0]   reg_rdata_o,
  input logic               irq_o,
  input logic [STEER_W-1:0] irq_num_o,
  input logic [DAT_W-1:0]   ev_i,
  input logic [DAT_W-1:0]   chg_i
);
  logic hit, rd_chg, wr_cfg;
  assign hit    = (reg_sel_i[IDX_W-1] == CTRL_ID) && (reg_sel_i[IDX_W-2] == SOCK_ID);
  assign rd_chg = reg_rd_i && hit && reg_sel_i[OFF_W-1:0] == OFF_CHG;
  assign wr_cfg = reg_wr_i && hit && reg_sel_i[OFF_W-1:0] == OFF_CFG;

  a_r2_foreign_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !hit) |-> reg_rdata_o == '0);

  a_r5_change_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i[BIT_CD] && !rd_chg) |=> chg_i[BIT_CD]);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_chg && ev_i == '0) |=> (chg_i == '0 && !irq_o));

  a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_chg && ev_i[BIT_CD]) |=> chg_i[BIT_CD]);

  a_r8_steer_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> irq_num_o == $past(reg_wdata_i[DAT_W-1 -: STEER_W]));

  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && (reg_wdata_i & SRC_MASK) == '0) |=> !irq_o);
endmodule

bind csc_irq_unit csc_irq_unit_chk #(.CTRL_ID(CTRL_ID), .SOCK_ID(SOCK_ID)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_sel_i  (reg_sel_i),
  .reg_rd_i   (reg_rd_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .irq_num_o  (irq_num_o),
  .ev_i       (ev_w),
  .chg_i      (chg_w)
);

// File: tb/sim_csc_irq_unit.sv
`timescale 1ns/1ps
module sim_csc_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] det = 2'b00, bvd = 2'b11;
  logic       wp = 1'b0, rdy = 1'b0, pwr = 1'b0;
  logic [7:0] sel = '0, wdata = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  logic [3:0] irq_num;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  csc_irq_unit #(.CTRL_ID(1'b0), .SOCK_ID(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .det_i(det), .bvd_i(bvd), .wp_i(wp),
    .rdy_i(rdy), .pwr_good_i(pwr), .reg_sel_i(sel), .reg_rd_i(rd),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .irq_num_o(irq_num)
  );

  localparam logic [7:0] I_STAT = 8'h41, I_CHG = 8'h44, I_CFG = 8'h45;

  // {inputs {pwr,rdy,wp,det,bvd}, expected status, expected change}
  localparam logic [23:0] VEC [8] = '{
    {8'h17, 8'h17, 8'h00},
    {8'h6F, 8'h6F, 8'h08},
    {8'h0E, 8'h0E, 8'h02},
    {8'h0C, 8'h0C, 8'h01},
    {8'h0F, 8'h0F, 8'h00},
    {8'h0B, 8'h0B, 8'h08},
    {8'h01, 8'h01, 8'h01},
    {8'h03, 8'h03, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    sel = idx; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; sel = '0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    sel = idx; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; sel = '0; wdata = '0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    int bad;
    // R10 reset state
    idle(2);
    #1 chk("R10 irq", {7'd0, irq}, 8'h00);
    chk("R10 irq_num", {4'd0, irq_num}, 8'h00);
    reg_read(I_CFG, d);
    chk("R10 cfg", d, 8'h00);
    rst_n = 1'b1;
    idle(5);
    reg_read(I_CHG, d); // discard start-up events
    // R8 config write, bit 2 masked
    reg_write(I_CFG, 8'h5F);
    reg_read(I_CFG, d);
    chk("R8 cfg readback", d, 8'h5B);
    #1 chk("R8 irq_num", {4'd0, irq_num}, 8'h05);

    // R1 R3 R4 R5 R9 vector walk
    for (int i = 0; i < 8; i++) begin
      {pwr, rdy, wp, det, bvd} = VEC[i][22:16];
      idle(4);
      #1 chk($sformatf("R9 irq row %0d", i), {7'd0, irq}, {7'd0, VEC[i][7:0] != 8'h00});
      reg_read(I_CHG, d);
      chk($sformatf("R3 R4 R5 change row %0d", i), d, VEC[i][7:0]);
      reg_read(I_STAT, d);
      chk($sformatf("R1 status row %0d", i), d, VEC[i][15:8]);
    end

    // R9 disabled source latches but stays quiet
    reg_write(I_CFG, 8'h30);
    det = 2'b11;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1 if (irq) bad++;
    end
    chk("R9 disabled irq cycles", bad[7:0], 8'h00);
    chk("R8 steer 3", {4'd0, irq_num}, 8'h03);
    reg_read(I_CHG, d);
    chk("R9 latched while disabled", d, 8'h08);

    // R6 battery warning, clear on read
    reg_write(I_CFG, 8'h02);
    bvd = 2'b10;
    idle(4);
    #1 chk("R9 warning irq", {7'd0, irq}, 8'h01);
    reg_read(I_CHG, d);
    chk("R4 warning bit", d, 8'h02);
    #1 chk("R6 irq low after read", {7'd0, irq}, 8'h00);

    // R7 event on the clearing edge
    reg_write(I_CFG, 8'h08);
    bvd = 2'b11;
    idle(5);
    det = 2'b00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_read(I_CHG, d);
    chk("R7 read before event", d, 8'h00);
    #1 chk("R7 irq after read", {7'd0, irq}, 8'h01);
    reg_read(I_CHG, d);
    chk("R7 event kept", d, 8'h08);

    // R2 foreign index
    reg_write(8'h05, 8'hFF);
    reg_read(I_CFG, d);
    chk("R2 foreign write", d, 8'h08);
    det = 2'b11;
    idle(4);
    reg_read(8'h04, d);
    chk("R2 foreign read sock", d, 8'h00);
    reg_read(8'hC4, d);
    chk("R2 foreign read ctrl", d, 8'h00);
    #1 chk("R2 event not cleared", {7'd0, irq}, 8'h01);
    reg_read(I_CHG, d);
    chk("R2 change intact", d, 8'h08);

    // R11 writes to read-only registers
    reg_write(I_CHG, 8'hFF);
    reg_write(I_STAT, 8'hFF);
    #1 chk("R11 irq", {7'd0, irq}, 8'h00);
    reg_read(I_CHG, d);
    chk("R11 change", d, 8'h00);
    reg_read(I_STAT, d);
    chk("R11 status", d, 8'h0F);

    summary();
  end
endmodule